// File: doc/BRIEF.md
# Two-bit burst address sequencer

This block produces the word address used by a synchronous burst memory during a four-beat burst. A burst starts when either of two active-low start strobes is sampled low on a rising clock edge. One strobe comes from the host processor and is honoured only while the primary select is low. The other comes from the memory controller and is always honoured. On that edge the full external address is captured and the beat index returns to zero.

After a burst has started, each edge where the active-low step input is low moves to the next beat. An edge where step is high holds the current beat. Only the low two address bits are sequenced. The upper bits keep the captured value. A static order input chooses between two burst orders. The first is interleaved: the start bits XOR the beat index. The second is linear: the start bits plus the beat index, modulo four. After the fourth beat, the next step returns to the first address of the same group of four.

The address and the beat index are driven straight from registers through a small mapping stage. A start edge is therefore visible on the outputs in the cycle that follows it.

Top module: `burst_addr_seq`

## Requirements
- R1: With `order_ilv` = 1, `cur_addr[1:0]` at beat index k (0..3) equals start[1:0] XOR k. For example, start 01 gives 01, 00, 11, 10.
- R2: With `order_ilv` = 0, `cur_addr[1:0]` at beat index k equals (start[1:0] + k) mod 4. For example, start 10 gives 10, 11, 00, 01.
- R3: When `ctl_start_n` is low at a rising edge, the next cycle shows `cur_addr` equal to the sampled `ext_addr` and `beat_idx` = 0. This holds whatever the levels of `prim_sel_n` and `step_n`.
- R4: When `cpu_start_n` and `prim_sel_n` are both low at a rising edge, the address is loaded in the same way as in R3.
- R5: While `prim_sel_n` is high, `cpu_start_n` has no effect. `cur_addr` and `beat_idx` behave exactly as if the strobe were high.
- R6: On an edge with no accepted start and `step_n` low, `beat_idx` increments by one. An accepted start takes priority over a step on the same edge.
- R7: On an edge with no accepted start and `step_n` high, `cur_addr` and `beat_idx` are held (burst suspend).
- R8: Bits [15:2] of `cur_addr` keep the captured value for the whole burst, whatever `ext_addr` does between starts.
- R9: A step taken at beat index 3 returns `beat_idx` to 0, and `cur_addr` returns to the first address of the burst. The address never crosses into the next group of four words.
- R10: While `rst_n` is low, `cur_addr` is 0 and `beat_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| order_ilv | input | 1 | Static burst order: 1 interleaved, 0 linear |
| cpu_start_n | input | 1 | Processor start strobe, active low, gated by prim_sel_n |
| ctl_start_n | input | 1 | Controller start strobe, active low, ungated |
| prim_sel_n | input | 1 | Primary select, active low |
| step_n | input | 1 | Advance to next beat, active low |
| ext_addr | input | 16 | External word address captured at a start |
| cur_addr | output | 16 | Current burst word address |
| beat_idx | output | 2 | Beat index 0..3 within the burst |

## Verification
The bench builds the block with its default parameters: a 16-bit address and a two-bit beat field. With these values the full four-beat wrap and every start position are reachable in a few cycles. In both orders, it runs all four start positions through a full burst plus a wrap step, with suspends in the middle. The upper address bits and the external address are changed between starts. Load priority over stepping and the gating of the processor strobe are exercised against a behavioural table model.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORDER_LINEAR = 1'b0,
    ORDER_ILV    = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_load_ctl.sv
module burst_load_ctl (
  input  logic cpu_start_n,
  input  logic ctl_start_n,
  input  logic prim_sel_n,
  input  logic step_n,
  output logic load,
  output logic step
);
  logic cpu_ok;

  always_comb begin
    cpu_ok = ~cpu_start_n & ~prim_sel_n;
    load   = cpu_ok | ~ctl_start_n;
    step   = ~load & ~step_n;
  end

  // R6: a load always wins over a step
  always_comb begin
    if (load) a_r6_load_beats_step: assert (!step);
  end
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] base_q
);
  logic [ADDR_W-1:0] base_d;

  always_comb begin
    base_d = base_q;
    if (load) base_d = ext_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else        base_q <= base_d;
  end

  a_r8_base_held: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(base_q));
endmodule

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  output logic [BEAT_W-1:0] beat_q
);
  localparam logic [BEAT_W-1:0] LAST = {BEAT_W{1'b1}};
  localparam logic [BEAT_W-1:0] ONE  = {{(BEAT_W-1){1'b0}}, 1'b1};

  logic [BEAT_W-1:0] beat_d;

  always_comb begin
    beat_d = beat_q;
    if (load)      beat_d = '0;
    else if (step) beat_d = beat_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beat_q <= '0;
    else        beat_q <= beat_d;
  end

  a_r7_suspend_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(beat_q));
  a_r9_wrap_to_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step && beat_q == LAST) |=> beat_q == '0);
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  burst_order_e      order,
  input  logic [BEAT_W-1:0] start,
  input  logic [BEAT_W-1:0] beat,
  output logic [BEAT_W-1:0] low
);
  logic [BEAT_W-1:0] ilv;
  logic [BEAT_W-1:0] lin;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
    assign ilv[b] = start[b] ^ beat[b];
  end

  assign lin = start + beat;

  always_comb begin
    low = (order == ORDER_ILV) ? ilv : lin;
  end

  // R1/R2: the first beat is the start position in either order
  always_comb begin
    if (beat == '0) a_r1_first_beat_is_start: assert (low == start);
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              order_ilv,
  input  logic              cpu_start_n,
  input  logic              ctl_start_n,
  input  logic              prim_sel_n,
  input  logic              step_n,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [BEAT_W-1:0] beat_idx
);
  logic              load;
  logic              step;
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] low;
  burst_order_e      order;

  assign order = burst_order_e'(order_ilv);

  burst_load_ctl u_ctl (
    .cpu_start_n (cpu_start_n),
    .ctl_start_n (ctl_start_n),
    .prim_sel_n  (prim_sel_n),
    .step_n      (step_n),
    .load        (load),
    .step        (step)
  );

  burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .ext_addr (ext_addr),
    .base_q   (base_q)
  );

  burst_beat_cnt #(.BEAT_W(BEAT_W)) u_beat (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .step   (step),
    .beat_q (beat_idx)
  );

  burst_order_map #(.BEAT_W(BEAT_W)) u_map (
    .order (order),
    .start (base_q[BEAT_W-1:0]),
    .beat  (beat_idx),
    .low   (low)
  );

  assign cur_addr = {base_q[ADDR_W-1:BEAT_W], low};

  a_r3_ctl_load: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_start_n |=> (cur_addr == $past(ext_addr)) && (beat_idx == '0));
  a_r5_cpu_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_start_n && prim_sel_n && ctl_start_n && step_n)
      |=> $stable(cur_addr) && $stable(beat_idx));
  a_r8_upper_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_start_n && (cpu_start_n || prim_sel_n))
      |=> $stable(cur_addr[ADDR_W-1:BEAT_W]));
endmodule

// File: tb/burst_addr_seq_test.sv
`timescale 1ns/1ps
module burst_addr_seq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        order_ilv;
  logic        cpu_start_n;
  logic        ctl_start_n;
  logic        prim_sel_n;
  logic        step_n;
  logic [15:0] ext_addr;
  logic [15:0] cur_addr;
  logic [1:0]  beat_idx;

  int compared = 0;
  int mismatched = 0;

  logic [15:0] m_base;
  int          m_beat;

  always #2.5 clk = ~clk;

  burst_addr_seq uut (
    .clk(clk), .rst_n(rst_n), .order_ilv(order_ilv),
    .cpu_start_n(cpu_start_n), .ctl_start_n(ctl_start_n),
    .prim_sel_n(prim_sel_n), .step_n(step_n),
    .ext_addr(ext_addr), .cur_addr(cur_addr), .beat_idx(beat_idx)
  );

  function automatic int ref_low(input logic ilv, input int start, input int k);
    if (ilv) return start ^ k;
    return (start + k) % 4;
  endfunction

  task automatic compare(input string tag);
    logic [15:0] exp_a;
    exp_a = {m_base[15:2], 2'(ref_low(order_ilv, int'(m_base[1:0]), m_beat))};
    compared++;
    if (cur_addr !== exp_a || int'(beat_idx) != m_beat) begin
      mismatched++;
      $display("FAIL %s: cur_addr=%h beat=%0d expected %h/%0d",
               tag, cur_addr, beat_idx, exp_a, m_beat);
    end
  endtask

  task automatic cyc(input logic cpu, input logic ctl, input logic sel,
                     input logic stp, input logic [15:0] a, input string tag);
    cpu_start_n = cpu; ctl_start_n = ctl; prim_sel_n = sel;
    step_n = stp; ext_addr = a;
    @(posedge clk);
    if ((!cpu && !sel) || !ctl) begin
      m_base = a; m_beat = 0;
    end else if (!stp) begin
      m_beat = (m_beat + 1) % 4;
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset(input logic ilv);
    rst_n = 1'b0; order_ilv = ilv;
    cpu_start_n = 1'b1; ctl_start_n = 1'b1; prim_sel_n = 1'b1; step_n = 1'b1;
    ext_addr = 16'hFFFF;
    m_base = '0; m_beat = 0;
    repeat (3) @(negedge clk);
    compare("R10");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R10");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not finish, expected end of test");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int md = 1; md >= 0; md--) begin
      string otag;
      otag = (md == 1) ? "R1" : "R2";
      do_reset(md[0]);
      for (int s = 0; s < 4; s++) begin
        logic [15:0] a;
        a = {14'(16'h1A53 + s * 16'h0731), 2'(s)};
        cyc(1, 0, 1, 1, a, "R3");
        cyc(1, 1, 1, 0, ~a, otag);
        cyc(1, 1, 1, 0, 16'h5555, "R8");
        cyc(1, 1, 1, 1, 16'hAAAA, "R7");
        cyc(1, 1, 1, 1, 16'h0F0F, "R7");
        cyc(1, 1, 1, 0, 16'hF0F0, otag);
        cyc(1, 1, 1, 0, 16'h1234, "R9");
        cyc(1, 1, 1, 0, 16'h4321, "R6");
      end
      cyc(0, 1, 0, 1, 16'hBEEE, "R4");
      cyc(1, 1, 0, 0, 16'h0000, "R6");
      cyc(0, 1, 1, 1, 16'h7777, "R5");
      cyc(0, 1, 1, 0, 16'h7777, "R5");
      cyc(0, 1, 1, 1, 16'h3333, "R5");
      cyc(1, 0, 0, 0, 16'hC0DE, "R6");
      cyc(0, 1, 0, 0, 16'h9ABD, "R6");
      cyc(1, 0, 1, 0, 16'h2462, "R3");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule